// File: doc/BRIEF.md
# Per-Processor Counter and User Timer

This block is the private timer of one processor. A mode input, owned by the system-level timer, picks one of two personalities for the same four-word register window. In counter mode the block is a periodic limit counter: the count lives above bit 9 of the word, advances one unit per 500 ns tick, wraps to zero on reaching a programmable limit, sets a reached flag and raises a processor-local interrupt. A limit of zero means the counter free-runs over its whole 22-bit unit range.

In user mode the limit and count words become the high and low halves of a 63-bit counter that software starts and stops through a control word. Reaching the fixed terminal value 0x7FFFFFFFFFFFFE00 wraps the counter and sets the reached flag, but the interrupt stays low. A change on the mode input is detected against a registered copy. On that clock edge the block carries out the transition actions, and bus accesses and ticks in that cycle are dropped.

Top module: `cpu_timer`

## Requirements
- R1: After reset the block is in counter mode and running. The limit is zero, the count is zero, the reached flag is clear and `irq` is low. Word 3 reads 1; words 0 and 1 read 0.
- R2: In counter mode each cycle with `tick` high adds 0x200 to the count. A read of word 1 returns the reached flag in bit 31 and the count in bits 30:9, with bits 8:0 zero.
- R3: In counter mode, a tick that makes the count equal to the limit returns the count to zero, sets the reached flag and raises `irq`. `irq` only rises in the cycle after a tick.
- R4: In counter mode a read of word 0 (`rd_en` high) returns the limit in bits 30:9 and clears both the reached flag and `irq`. When a limit hit falls in the same cycle, the flag and `irq` end up set.
- R5: In counter mode a write to word 0 sets the limit from bits 30:9, zeroes the count and lowers `irq`, and this wins over a tick in the same cycle. A write to word 2 sets the limit and leaves the count alone. Word 2 reads 0.
- R6: In counter mode, writes to word 1 and word 3 change neither the count nor the running bit.
- R7: On the edge where the mode input first differs from its registered copy and is 1, the block enters user mode. That edge lowers `irq`, stops the counter, clears the running bit and zeroes the count. Bus writes in that cycle are ignored.
- R8: In user mode `irq` never rises. A tick that brings the count to 0x7FFFFFFFFFFFFE00 wraps it to zero and sets the reached flag.
- R9: In user mode a read of word 0 returns the count bits 62:32 in bits 30:0 and the reached flag in bit 31. The read does not clear the flag.
- R10: In user mode a write to word 0 loads count bits 62:32 from data bits 30:0. A write to word 1 loads count bits 31:9 from data bits 31:9. Either write clears the reached flag, and the load wins over a same-cycle tick. Word 1 reads the low 32 count bits with bits 8:0 zero.
- R11: In user mode a write to word 3 sets the running bit to data bit 0. Word 3 reads the running bit in bit 0. The count holds while the running bit is 0.
- R12: On the edge where the mode input returns to 0, the block enters counter mode with the running bit set and the count zeroed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-cycle pulse per 500 ns count period |
| user_mode | input | 1 | Mode select from the system timer: 1 = user, 0 = counter |
| sel | input | 2 | Word index within the register window |
| wr_en | input | 1 | Write strobe for the selected word |
| rd_en | input | 1 | Read strobe; enables read side effects |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Contents of the selected word, combinational |
| irq | output | 1 | Processor-local interrupt, high while pending |

## Verification
Several events can land on the same clock edge: a tick that hits the limit together with a read of word 0 that clears the flag; a tick together with a load of the count; and a mode change together with a tick and a write to the control word. The bench forces each coincidence by driving both stimuli in one cycle. It then judges the outcome from the ports: for the first case the flag and `irq` must still be set; for the second the loaded value must show with no tick added; for the third the running bit must read 0 and `irq` must be low.

// File: rtl/cpu_timer_pkg.sv
// Package: shared word indices and decoded-access strobes for the
// per-processor timer. Assumes a four-word register window.
package cpu_timer_pkg;

    // Word index inside the window; the index values are visible to software.
    typedef enum logic [1:0] {
        SEL_TOP     = 2'd0,  // limit (counter mode) / count high (user mode)
        SEL_LOW     = 2'd1,  // count (counter mode) / count low (user mode)
        SEL_LIMKEEP = 2'd2,  // limit load that keeps the count
        SEL_RUN     = 2'd3   // run control
    } sel_e;

    // One strobe per register action, already qualified by mode.
    typedef struct packed {
        logic ld_lim_rst;   // load limit, zero count, drop irq
        logic ld_lim_keep;  // load limit only
        logic ld_high;      // load count high half
        logic ld_low;       // load count low half
        logic run_wr;       // write running bit
        logic rd_clear;     // read of limit word clears flag and irq
    } act_t;

endpackage

// File: rtl/cpu_timer_decode.sv
// Module: turns bus strobes and word index into action strobes.
// Assumes: mode_q is the effective mode; xfer marks a mode-change cycle,
// in which every bus action is dropped.
module cpu_timer_decode
    import cpu_timer_pkg::*;
(
    input  logic       mode_q,
    input  logic       xfer,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] sel,
    output act_t       act
);

    sel_e sel_w;
    logic wr_ok;
    logic rd_ok;

    // Qualify strobes; a mode change swallows the access.
    always_comb begin
        sel_w = sel_e'(sel);
        wr_ok = wr_en && !xfer;
        rd_ok = rd_en && !xfer;
    end

    // Map word index and mode to register actions (R5, R6, R10, R11, R4).
    always_comb begin
        act             = '0;
        act.ld_lim_rst  = wr_ok && (sel_w == SEL_TOP) && !mode_q;
        act.ld_lim_keep = wr_ok && (sel_w == SEL_LIMKEEP);
        act.ld_high     = wr_ok && (sel_w == SEL_TOP) && mode_q;
        act.ld_low      = wr_ok && (sel_w == SEL_LOW) && mode_q;
        act.run_wr      = wr_ok && (sel_w == SEL_RUN) && mode_q;
        act.rd_clear    = rd_ok && (sel_w == SEL_TOP) && !mode_q;
    end

endmodule

// File: rtl/cpu_timer_count.sv
// Module: count register in tick units plus the limit register.
// Assumes: the count is kept in units of 2**TICK_LSB; the counter-mode
// count never exceeds LIM_W bits because every mode change zeroes it.
module cpu_timer_count #(
    parameter int WORD_W   = 32,
    parameter int TICK_LSB = 9,
    localparam int WIDE_W  = 2 * WORD_W - 1,
    localparam int PER_W   = WIDE_W - TICK_LSB,
    localparam int LOW_PW  = WORD_W - TICK_LSB,
    localparam int HIGH_W  = PER_W - LOW_PW,
    localparam int LIM_W   = WORD_W - 1 - TICK_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_q,
    input  logic              xfer,
    input  logic              running,
    input  logic              tick,
    input  logic              ld_lim_rst,
    input  logic              ld_lim_keep,
    input  logic              ld_high,
    input  logic              ld_low,
    input  logic [LOW_PW-1:0] wr_field,
    input  logic [HIGH_W-1:0] wr_hi,
    output logic [PER_W-1:0]  per_q,
    output logic [LIM_W-1:0]  lim_q,
    output logic              hit
);

    logic [PER_W:0] nxt_x;
    logic [PER_W:0] term_x;
    logic           ld_any;

    // Terminal value in units: fixed all-ones in user mode, else the limit
    // (zero limit means the full counter-mode range) (R3, R8).
    always_comb begin
        if (mode_q)
            term_x = {1'b0, {PER_W{1'b1}}};
        else if (lim_q == '0)
            term_x = {{(PER_W + 1 - LIM_W){1'b0}}, {LIM_W{1'b1}}};
        else
            term_x = {{(PER_W + 1 - LIM_W){1'b0}}, lim_q};
    end

    // Next value and terminal detection; loads and mode changes win.
    always_comb begin
        nxt_x  = {1'b0, per_q} + {{PER_W{1'b0}}, 1'b1};
        ld_any = ld_lim_rst || ld_high || ld_low;
        hit    = running && tick && !xfer && !ld_any && (nxt_x >= term_x);
    end

    // Count register: mode change > reset-load > half loads > wrap > advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            per_q <= '0;
        else if (xfer || ld_lim_rst)
            per_q <= '0;
        else if (ld_high)
            per_q[PER_W-1 -: HIGH_W] <= wr_hi;
        else if (ld_low)
            per_q[LOW_PW-1:0] <= wr_field;
        else if (hit)
            per_q <= '0;
        else if (running && tick)
            per_q <= nxt_x[PER_W-1:0];
    end

    // Limit register, loaded from word 0 (counter mode) or word 2.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim_q <= '0;
        else if (ld_lim_rst || ld_lim_keep)
            lim_q <= wr_field[LIM_W-1:0];
    end

endmodule

// File: rtl/cpu_timer_flags.sv
// Module: mode tracking, running bit, reached flag and interrupt.
// Assumes: act strobes are already qualified by mode and by xfer.
module cpu_timer_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic user_mode,
    input  logic hit,
    input  logic ld_lim_rst,
    input  logic ld_high,
    input  logic ld_low,
    input  logic run_wr,
    input  logic run_bit,
    input  logic rd_clear,
    output logic mode_q,
    output logic xfer,
    output logic running,
    output logic reached,
    output logic irq
);

    logic enter_user;
    logic leave_user;

    // Mode-change detection against the registered copy (R7, R12).
    always_comb begin
        xfer       = (user_mode != mode_q);
        enter_user = xfer && user_mode;
        leave_user = xfer && !user_mode;
    end

    // Registered copy of the mode input.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= user_mode;
    end

    // Running bit: stop on entering user mode, run on leaving it (R11).
    always_ff @(posedge clk) begin
        if (!rst_n)          running <= 1'b1;
        else if (enter_user) running <= 1'b0;
        else if (leave_user) running <= 1'b1;
        else if (run_wr)     running <= run_bit;
    end

    // Reached flag: a hit wins over any same-cycle clear (R4).
    always_ff @(posedge clk) begin
        if (!rst_n)                             reached <= 1'b0;
        else if (hit)                           reached <= 1'b1;
        else if (ld_high || ld_low || rd_clear) reached <= 1'b0;
    end

    // Interrupt: counter-mode hits only (R3, R8).
    always_ff @(posedge clk) begin
        if (!rst_n)                      irq <= 1'b0;
        else if (enter_user)             irq <= 1'b0;
        else if (hit && !mode_q)         irq <= 1'b1;
        else if (ld_lim_rst || rd_clear) irq <= 1'b0;
    end

endmodule

// File: rtl/cpu_timer.sv
// Module: per-processor timer with counter and user personalities.
// Assumes: tick is a one-cycle enable per count period; rd_data is
// combinational and rd_en only gates read side effects.
module cpu_timer
    import cpu_timer_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int TICK_LSB = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              user_mode,
    input  logic [1:0]        sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              irq
);

    localparam int WIDE_W = 2 * WORD_W - 1;
    localparam int PER_W  = WIDE_W - TICK_LSB;
    localparam int LOW_PW = WORD_W - TICK_LSB;
    localparam int HIGH_W = PER_W - LOW_PW;
    localparam int LIM_W  = WORD_W - 1 - TICK_LSB;

    act_t              act;
    logic              mode_q;
    logic              xfer;
    logic              running;
    logic              reached;
    logic              hit;
    logic [PER_W-1:0]  per_q;
    logic [LIM_W-1:0]  lim_q;

    cpu_timer_decode u_dec (
        .mode_q (mode_q),
        .xfer   (xfer),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .sel    (sel),
        .act    (act)
    );

    cpu_timer_count #(
        .WORD_W   (WORD_W),
        .TICK_LSB (TICK_LSB)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_q      (mode_q),
        .xfer        (xfer),
        .running     (running),
        .tick        (tick),
        .ld_lim_rst  (act.ld_lim_rst),
        .ld_lim_keep (act.ld_lim_keep),
        .ld_high     (act.ld_high),
        .ld_low      (act.ld_low),
        .wr_field    (wr_data[WORD_W-1:TICK_LSB]),
        .wr_hi       (wr_data[HIGH_W-1:0]),
        .per_q       (per_q),
        .lim_q       (lim_q),
        .hit         (hit)
    );

    cpu_timer_flags u_flg (
        .clk        (clk),
        .rst_n      (rst_n),
        .user_mode  (user_mode),
        .hit        (hit),
        .ld_lim_rst (act.ld_lim_rst),
        .ld_high    (act.ld_high),
        .ld_low     (act.ld_low),
        .run_wr     (act.run_wr),
        .run_bit    (wr_data[0]),
        .rd_clear   (act.rd_clear),
        .mode_q     (mode_q),
        .xfer       (xfer),
        .running    (running),
        .reached    (reached),
        .irq        (irq)
    );

    // Read mux: the same words change meaning with the mode (R2, R9, R10).
    always_comb begin
        rd_data = '0;
        case (sel_e'(sel))
            SEL_TOP:
                rd_data = mode_q ? {reached, per_q[PER_W-1 -: HIGH_W]}
                                 : {1'b0, lim_q, {TICK_LSB{1'b0}}};
            SEL_LOW:
                rd_data = mode_q ? {per_q[LOW_PW-1:0], {TICK_LSB{1'b0}}}
                                 : {reached, per_q[LIM_W-1:0], {TICK_LSB{1'b0}}};
            SEL_RUN:
                rd_data = {{(WORD_W - 1){1'b0}}, running};
            default:
                rd_data = '0;
        endcase
    end

endmodule

// File: rtl/cpu_timer_chk.sv
// Module: property checker for cpu_timer, attached by bind.
// Assumes: names below match the internal signals of the top module.
module cpu_timer_chk #(
    parameter int PER_W = 54
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             user_mode,
    input logic             wr_en,
    input logic [1:0]       sel,
    input logic             mode_q,
    input logic             running,
    input logic             irq,
    input logic [PER_W-1:0] per_q
);

    // R8: no interrupt while user mode is in effect.
    a_r8_no_irq_user: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> !irq);

    // R7: entering user mode leaves the counter stopped.
    a_r7_stop_on_enter: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_q) |-> !running);

    // R12: leaving user mode leaves the counter running.
    a_r12_run_on_leave: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_q) |-> running);

    // R3: the interrupt only rises after a tick.
    a_r3_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick));

    // R6: a counter-mode write to word 1 leaves the count alone.
    a_r6_low_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && (user_mode == mode_q) && wr_en && (sel == 2'd1) && !tick)
        |=> $stable(per_q));

    // R11: a stopped user counter holds when no write arrives.
    a_r11_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !running && (user_mode == mode_q) && !wr_en)
        |=> $stable(per_q));

endmodule

bind cpu_timer cpu_timer_chk #(.PER_W(PER_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .user_mode (user_mode),
    .wr_en     (wr_en),
    .sel       (sel),
    .mode_q    (mode_q),
    .running   (running),
    .irq       (irq),
    .per_q     (per_q)
);

// File: tb/cpu_timer_test.sv
// Bench: vector table walk, then directed coincidence and reset tests.
module cpu_timer_test;

    localparam logic [2:0] K_TICK = 3'd0;
    localparam logic [2:0] K_WR   = 3'd1;
    localparam logic [2:0] K_PEEK = 3'd2;
    localparam logic [2:0] K_RD   = 3'd3;
    localparam logic [2:0] K_IRQ  = 3'd4;
    localparam logic [2:0] K_MODE = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sel;
        logic [31:0] dat;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 58;
    localparam vec_t VEC [NV] = '{
        '{K_PEEK, 2'd1, 32'h0, 32'h0, 8'd1},              // R1 count zero
        '{K_PEEK, 2'd3, 32'h0, 32'h1, 8'd1},              // R1 running
        '{K_PEEK, 2'd0, 32'h0, 32'h0, 8'd1},              // R1 limit zero
        '{K_IRQ,  2'd0, 32'h0, 32'h0, 8'd1},              // R1 irq low
        '{K_TICK, 2'd0, 32'h0, 32'h0, 8'd2},
        '{K_TICK, 2'd0, 32'h0, 32'h0, 8'd2},
        '{K_PEEK, 2'd1, 32'h0, 32'h400, 8'd2},            // R2 two units
        '{K_WR,   2'd0, 32'h600, 32'h0, 8'd5},            // limit 3 units
        '{K_PEEK, 2'd1, 32'h0, 32'h0, 8'd5},              // R5 count zeroed
        '{K_PEEK, 2'd0, 32'h0, 32'h600, 8'd5},            // R5 limit read
        '{K_TICK, 2'd0, 32'h0, 32'h0, 8'd2},
        '{K_TICK, 2'd0, 32'h0, 32'h0, 8'd2},
        '{K_PEEK, 2'd1, 32'h0, 32'h400, 8'd2},            // R2
        '{K_TICK, 2'd0, 32'h0, 32'h0, 8'd3},
        '{K_PEEK, 2'd1, 32'h0, 32'h80000000, 8'd3},       // R3 wrap + flag
        '{K_IRQ,  2'd0, 32'h0, 32'h1, 8'd3},              // R3 irq
        '{K_RD,   2'd0, 32'h0, 32'h600, 8'd4},            // R4 read limit
        '{K_IRQ,  2'd0, 32'h0, 32'h0, 8'd4},              // R4 irq cleared
        '{K_PEEK, 2'd1, 32'h0, 32'h0, 8'd4},              // R4 flag cleared
        '{K_WR,   2'd1, 32'hFFFFFFFF, 32'h0, 8'd6},
        '{K_WR,   2'd3, 32'h0, 32'h0, 8'd6},
        '{K_PEEK, 2'd1, 32'h0, 32'h0, 8'd6},              // R6 count kept
        '{K_PEEK, 2'd3, 32'h0, 32'h1, 8'd6},              // R6 still running
        '{K_TICK, 2'd0, 32'h0, 32'h0, 8'd5},
        '{K_WR,   2'd2, 32'hA00, 32'h0, 8'd5},
        '{K_PEEK, 2'd1, 32'h0, 32'h200, 8'd5},            // R5 count kept
        '{K_PEEK, 2'd0, 32'h0, 32'hA00, 8'd5},            // R5 new limit
        '{K_PEEK, 2'd2, 32'h0, 32'h0, 8'd5},              // R5 word 2 reads 0
        '{K_MODE, 2'd0, 32'h1, 32'h0, 8'd7},
        '{K_PEEK, 2'd3, 32'h0, 32'h0, 8'd7},              // R7 stopped
        '{K_PEEK, 2'd1, 32'h0, 32'h0, 8'd7},              // R7 count zeroed
        '{K_TICK, 2'd0, 32'h0, 32'h0, 8'd11},
        '{K_PEEK, 2'd1, 32'h0, 32'h0, 8'd11},             // R11 holds
        '{K_WR,   2'd3, 32'h1, 32'h0, 8'd11},
        '{K_PEEK, 2'd3, 32'h0, 32'h1, 8'd11},             // R11 started
        '{K_TICK, 2'd0, 32'h0, 32'h0, 8'd11},
        '{K_TICK, 2'd0, 32'h0, 32'h0, 8'd11},
        '{K_TICK, 2'd0, 32'h0, 32'h0, 8'd11},
        '{K_PEEK, 2'd1, 32'h0, 32'h600, 8'd11},           // R11 advanced
        '{K_WR,   2'd0, 32'h5, 32'h0, 8'd10},
        '{K_PEEK, 2'd0, 32'h0, 32'h5, 8'd9},              // R9 high half
        '{K_PEEK, 2'd1, 32'h0, 32'h600, 8'd10},           // R10 low kept
        '{K_WR,   2'd1, 32'h12345FFF, 32'h0, 8'd10},
        '{K_PEEK, 2'd1, 32'h0, 32'h12345E00, 8'd10},      // R10 low load
        '{K_TICK, 2'd0, 32'h0, 32'h0, 8'd10},
        '{K_PEEK, 2'd1, 32'h0, 32'h12346000, 8'd10},      // R10 continues
        '{K_WR,   2'd0, 32'h7FFFFFFF, 32'h0, 8'd8},
        '{K_WR,   2'd1, 32'hFFFFFC00, 32'h0, 8'd8},
        '{K_TICK, 2'd0, 32'h0, 32'h0, 8'd8},
        '{K_PEEK, 2'd0, 32'h0, 32'h80000000, 8'd8},       // R8 wrap + flag
        '{K_IRQ,  2'd0, 32'h0, 32'h0, 8'd8},              // R8 no irq
        '{K_RD,   2'd0, 32'h0, 32'h80000000, 8'd9},
        '{K_PEEK, 2'd0, 32'h0, 32'h80000000, 8'd9},       // R9 no clear
        '{K_WR,   2'd1, 32'h0, 32'h0, 8'd10},
        '{K_PEEK, 2'd0, 32'h0, 32'h0, 8'd10},             // R10 flag cleared
        '{K_MODE, 2'd0, 32'h0, 32'h0, 8'd12},
        '{K_PEEK, 2'd3, 32'h0, 32'h1, 8'd12},             // R12 running
        '{K_PEEK, 2'd1, 32'h0, 32'h0, 8'd12}              // R12 count zeroed
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        user_mode = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    logic [31:0] seen;
    logic        seen_irq;
    logic        mode_now = 1'b0;
    logic        done = 1'b0;
    int          nchk = 0;
    int          nfail = 0;

    cpu_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .user_mode (user_mode),
        .sel       (sel),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    always #5 clk = ~clk;

    // One bus cycle: drive after the falling edge, sample before the rising.
    task automatic cyc(input logic t, input logic w, input logic r,
                       input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        tick = t; wr_en = w; rd_en = r; sel = s; wr_data = d;
        user_mode = mode_now;
        #1;
        seen     = rd_data;
        seen_irq = irq;
    endtask

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                K_TICK: cyc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
                K_WR:   cyc(1'b0, 1'b1, 1'b0, VEC[i].sel, VEC[i].dat);
                K_PEEK: begin
                    cyc(1'b0, 1'b0, 1'b0, VEC[i].sel, 32'h0);
                    chk($sformatf("R%0d vec %0d", VEC[i].req, i), seen, VEC[i].exp);
                end
                K_RD: begin
                    cyc(1'b0, 1'b0, 1'b1, VEC[i].sel, 32'h0);
                    chk($sformatf("R%0d vec %0d", VEC[i].req, i), seen, VEC[i].exp);
                end
                K_IRQ: begin
                    cyc(1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
                    chk($sformatf("R%0d vec %0d irq", VEC[i].req, i),
                        {31'b0, seen_irq}, VEC[i].exp);
                end
                default: begin
                    mode_now = VEC[i].dat[0];
                    cyc(1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
                end
            endcase
        end

        // R4: limit hit and clearing read on the same edge; the set wins.
        cyc(1'b0, 1'b1, 1'b0, 2'd0, 32'h400);
        cyc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
        cyc(1'b1, 1'b0, 1'b1, 2'd0, 32'h0);
        chk("R4 read during hit", seen, 32'h400);
        cyc(1'b0, 1'b0, 1'b0, 2'd1, 32'h0);
        chk("R4 flag survives", seen, 32'h80000000);
        chk("R4 irq survives", {31'b0, seen_irq}, 32'h1);

        // R5: limit write with a terminal tick; the load wins, irq drops.
        cyc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
        cyc(1'b1, 1'b1, 1'b0, 2'd0, 32'h400);
        cyc(1'b0, 1'b0, 1'b0, 2'd1, 32'h0);
        chk("R5 load beats tick", seen, 32'h80000000);
        chk("R5 irq lowered", {31'b0, seen_irq}, 32'h0);

        // R7: mode change with tick and start write in the same cycle.
        cyc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
        cyc(1'b1, 1'b0, 1'b0, 2'd0, 32'h0);
        cyc(1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
        chk("R3 irq before change", {31'b0, seen_irq}, 32'h1);
        mode_now = 1'b1;
        cyc(1'b1, 1'b1, 1'b0, 2'd3, 32'h1);
        cyc(1'b0, 1'b0, 1'b0, 2'd3, 32'h0);
        chk("R7 write dropped, stopped", seen, 32'h0);
        chk("R7 irq lowered", {31'b0, seen_irq}, 32'h0);
        cyc(1'b0, 1'b0, 1'b0, 2'd1, 32'h0);
        chk("R7 count zero", seen, 32'h0);

        // R10: user load and tick in the same cycle.
        cyc(1'b0, 1'b1, 1'b0, 2'd3, 32'h1);
        cyc(1'b1, 1'b1, 1'b0, 2'd1, 32'h400);
        cyc(1'b0, 1'b0, 1'b0, 2'd1, 32'h0);
        chk("R10 load beats tick", seen, 32'h400);

        // R1: reset in the middle of user-mode activity.
        mode_now = 1'b0;
        @(negedge clk);
        rst_n = 1'b0; user_mode = 1'b0; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 2'd1, 32'h0);
        chk("R1 count after reset", seen, 32'h0);
        chk("R1 irq after reset", {31'b0, seen_irq}, 32'h0);
        cyc(1'b0, 1'b0, 1'b0, 2'd3, 32'h0);
        chk("R1 running after reset", seen, 32'h1);
        cyc(1'b0, 1'b0, 1'b0, 2'd0, 32'h0);
        chk("R1 limit after reset", seen, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule